// File: doc/BRIEF.md
# Indirect MMD Register Access Bridge

This block sits behind a 32-entry management register port on the PHY side and opens a wider register space, addressed by a device number and a 16-bit register index, through only two of those entries. Register 13 is the access-control register. Its low five bits name the target device. Its top two bits pick what register 14 does. Register 14 is the access-data register. It either latches a register index for the named device or moves data to and from the selected register. In data mode it can also advance the index after each access.

Software reaches an extended register in four steps. It writes register 13 with the device number and the address function. It writes register 14 with the index. It writes register 13 again with the same device and a data function. Then it reads or writes register 14. Each device keeps its own latched index, so moving to another device and back resumes where it left off.

The extended space is modelled inside the block and holds a small set of energy-efficient-link registers:
- a PCS control word carrying a clock-stop-enable bit;
- a fixed capability word;
- a saturating wake-error counter that clears when read;
- a writable advertisement word;
- a link-partner ability word driven from an input.

Top module: `mmd_indirect_bridge`

## Requirements
- R1: Register 13 stores all 16 bits written to it and returns them on read. It resets to 0x0000.
- R2: With function 00 (control bits [15:14]), a write to register 14 latches the index for the device in control bits [4:0], and a read of register 14 returns that latched index.
- R3: With function 01, register 14 reads and writes the selected register and leaves the latched index unchanged.
- R4: With function 10, the latched index advances by one after every read and every write of register 14.
- R5: With function 11, the latched index advances by one after every write of register 14 and stays put on reads.
- R6: Each of the 32 device numbers has its own latched index, and writing one leaves the others unchanged. All indices reset to 0.
- R7: Device 3 index 0 returns the clock-stop-enable flag in bit 10 and 0 in every other bit; only bit 10 is writable. Device 7 index 60 (advertisement) has writable bits [6:1] and reads 0 elsewhere. Both reset to 0.
- R8: Device 3 index 20 returns parameter EEE_CAP masked to bits [6:1]. Device 7 index 61 returns input lp_ability masked to bits [6:1]. Writes to either are ignored. The ability bits are: 1 = 100TX, 2 = 1000T, 3 = 10GT, 4 = 1000KX, 5 = 10GKX4, 6 = 10GKR.
- R9: Device 3 index 22 counts the cycles with wake_err high and saturates at 0xFFFF. A data-mode read of it returns the count and clears it. If wake_err is high in the clearing cycle, the count becomes 1.
- R10: Reads of unimplemented devices or indices, and reads of any management register other than 13 and 14, return 0x0000. Writes to them change nothing.
- R11: The index advance wraps from 0xFFFF to 0x0000.
- R12: The rd_data output is updated one cycle after rd_en, and rd_valid is high for exactly that cycle. The clk_stop_en output follows the device 3 index 0 bit 10 flag, and eee_adv follows the device 7 index 60 value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_num | input | 5 | Management register number for the access |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| wr_data | input | 16 | Write data |
| lp_ability | input | 16 | Link-partner ability bits shown at device 7 index 61 |
| wake_err | input | 1 | One count per cycle high for the wake-error counter |
| rd_data | output | 16 | Read data, registered |
| rd_valid | output | 1 | High the cycle after a read strobe |
| clk_stop_en | output | 1 | Clock-stop-enable flag |
| eee_adv | output | 16 | Current advertisement word |

## Verification
The assertions assume that a read strobe and a write strobe never occur in the same cycle, because the block gives no priority between them. One property checks this assumption at the inputs. The bench drives every access through one-cycle write or read tasks that raise exactly one strobe. It changes inputs only on the falling edge, so the properties about control-register holding, the read-valid pulse and the stability of the advertisement and clock-stop outputs are evaluated only on traffic that obeys this assumption.

// File: rtl/mmd_bridge_pkg.sv
package mmd_bridge_pkg;

    localparam int DATA_W = 16;
    localparam int DEV_W  = 5;

    typedef enum logic [1:0] {
        FN_ADDR   = 2'b00,
        FN_DATA   = 2'b01,
        FN_INC_RW = 2'b10,
        FN_INC_WR = 2'b11
    } mmd_fn_e;

    localparam logic [4:0] REG_CTRL = 5'd13;
    localparam logic [4:0] REG_DATA = 5'd14;

    localparam logic [DEV_W-1:0] DEV_PCS = 5'd3;
    localparam logic [DEV_W-1:0] DEV_AN  = 5'd7;

    localparam logic [DATA_W-1:0] IDX_PCS_CTRL = 16'd0;
    localparam logic [DATA_W-1:0] IDX_CAP      = 16'd20;
    localparam logic [DATA_W-1:0] IDX_WAKE     = 16'd22;
    localparam logic [DATA_W-1:0] IDX_ADV      = 16'd60;
    localparam logic [DATA_W-1:0] IDX_LP       = 16'd61;

    localparam logic [DATA_W-1:0] ABIL_MASK    = 16'h007E;
    localparam logic [DATA_W-1:0] CLKSTOP_MASK = 16'h0400;

endpackage

// File: rtl/mmd_addr_bank.sv
module mmd_addr_bank #(
    parameter int DEV_W  = 5,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  sel_dev,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] cur_addr
);
    localparam int NUM_DEV = 1 << DEV_W;

    logic [ADDR_W-1:0] addr_vec [NUM_DEV];

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
        logic [ADDR_W-1:0] addr_d, addr_q;
        logic              hit;

        assign hit = (sel_dev == DEV_W'(g));

        always_comb begin
            addr_d = addr_q;
            if (hit && load_en) begin
                addr_d = load_val;
            end else if (hit && inc_en) begin
                addr_d = addr_q + ADDR_W'(1);
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                addr_q <= '0;
            end else begin
                addr_q <= addr_d;
            end
        end

        assign addr_vec[g] = addr_q;
    end

    assign cur_addr = addr_vec[sel_dev];

endmodule

// File: rtl/mmd_reg_file.sv
module mmd_reg_file
    import mmd_bridge_pkg::*;
#(
    parameter logic [DATA_W-1:0] EEE_CAP = 16'h0006
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DEV_W-1:0]  dev,
    input  logic [DATA_W-1:0] idx,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              rd_en,
    input  logic              wake_inc,
    input  logic [DATA_W-1:0] lp_ability,
    output logic [DATA_W-1:0] rd_val,
    output logic              clk_stop_en,
    output logic [DATA_W-1:0] eee_adv
);
    typedef struct packed {
        logic              clk_stop;
        logic [DATA_W-1:0] adv;
        logic [DATA_W-1:0] wake_cnt;
    } file_state_t;

    file_state_t st_d, st_q;

    logic hit_ctrl, hit_cap, hit_wake, hit_adv, hit_lp;

    always_comb begin
        hit_ctrl = (dev == DEV_PCS) && (idx == IDX_PCS_CTRL);
        hit_cap  = (dev == DEV_PCS) && (idx == IDX_CAP);
        hit_wake = (dev == DEV_PCS) && (idx == IDX_WAKE);
        hit_adv  = (dev == DEV_AN)  && (idx == IDX_ADV);
        hit_lp   = (dev == DEV_AN)  && (idx == IDX_LP);
    end

    always_comb begin
        rd_val = '0;
        if (hit_ctrl) rd_val = st_q.clk_stop ? CLKSTOP_MASK : '0;
        if (hit_cap)  rd_val = EEE_CAP & ABIL_MASK;
        if (hit_wake) rd_val = st_q.wake_cnt;
        if (hit_adv)  rd_val = st_q.adv;
        if (hit_lp)   rd_val = lp_ability & ABIL_MASK;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en && hit_ctrl) begin
            st_d.clk_stop = |(wr_val & CLKSTOP_MASK);
        end
        if (wr_en && hit_adv) begin
            st_d.adv = wr_val & ABIL_MASK;
        end
        if (rd_en && hit_wake) begin
            st_d.wake_cnt = wake_inc ? DATA_W'(1) : '0;
        end else if (wake_inc && (st_q.wake_cnt != '1)) begin
            st_d.wake_cnt = st_q.wake_cnt + DATA_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign clk_stop_en = st_q.clk_stop;
    assign eee_adv     = st_q.adv;

endmodule

// File: rtl/mmd_indirect_bridge.sv
module mmd_indirect_bridge
    import mmd_bridge_pkg::*;
#(
    parameter logic [15:0] EEE_CAP = 16'h0006
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [4:0]  reg_num,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [15:0] wr_data,
    input  logic [15:0] lp_ability,
    input  logic        wake_err,
    output logic [15:0] rd_data,
    output logic        rd_valid,
    output logic        clk_stop_en,
    output logic [15:0] eee_adv
);
    typedef struct packed {
        logic [DATA_W-1:0] ctrl;
        logic [DATA_W-1:0] rd_data;
        logic              rd_valid;
    } top_state_t;

    top_state_t state_d, state_q;

    mmd_fn_e           fn;
    logic [DEV_W-1:0]  dev;
    logic              data_wr, data_rd;
    logic              bank_load, bank_inc;
    logic              file_wr, file_rd;
    logic [DATA_W-1:0] cur_addr;
    logic [DATA_W-1:0] file_val;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] ctrl_q;

    assign ctrl_q = state_q.ctrl;

    always_comb begin
        fn        = mmd_fn_e'(state_q.ctrl[15:14]);
        dev       = state_q.ctrl[DEV_W-1:0];
        data_wr   = wr_en && (reg_num == REG_DATA);
        data_rd   = rd_en && (reg_num == REG_DATA);
        bank_load = data_wr && (fn == FN_ADDR);
        file_wr   = data_wr && (fn != FN_ADDR);
        file_rd   = data_rd && (fn != FN_ADDR);
        bank_inc  = (file_wr && ((fn == FN_INC_RW) || (fn == FN_INC_WR)))
                 || (file_rd && (fn == FN_INC_RW));
    end

    mmd_addr_bank #(
        .DEV_W  (DEV_W),
        .ADDR_W (DATA_W)
    ) addr_bank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_dev  (dev),
        .load_en  (bank_load),
        .load_val (wr_data),
        .inc_en   (bank_inc),
        .cur_addr (cur_addr)
    );

    mmd_reg_file #(
        .EEE_CAP (EEE_CAP)
    ) reg_file_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .dev         (dev),
        .idx         (cur_addr),
        .wr_en       (file_wr),
        .wr_val      (wr_data),
        .rd_en       (file_rd),
        .wake_inc    (wake_err),
        .lp_ability  (lp_ability),
        .rd_val      (file_val),
        .clk_stop_en (clk_stop_en),
        .eee_adv     (eee_adv)
    );

    always_comb begin
        rd_val = '0;
        if (reg_num == REG_CTRL) begin
            rd_val = state_q.ctrl;
        end else if (reg_num == REG_DATA) begin
            rd_val = (fn == FN_ADDR) ? cur_addr : file_val;
        end
    end

    always_comb begin
        state_d          = state_q;
        state_d.rd_valid = rd_en;
        if (rd_en) begin
            state_d.rd_data = rd_val;
        end
        if (wr_en && (reg_num == REG_CTRL)) begin
            state_d.ctrl = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_data  = state_q.rd_data;
    assign rd_valid = state_q.rd_valid;

endmodule

// File: rtl/mmd_indirect_bridge_chk.sv
module mmd_indirect_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [4:0]  reg_num,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] wr_data,
    input logic [15:0] rd_data,
    input logic        rd_valid,
    input logic        clk_stop_en,
    input logic [15:0] eee_adv,
    input logic [15:0] ctrl_q
);
    // Input assumption: one strobe per cycle (R12)
    p_one_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en));

    p_valid_follows_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    p_valid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    p_ctrl_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_num == 5'd13) |=> (ctrl_q == $past(wr_data)));

    p_ctrl_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_num == 5'd13) |=> $stable(ctrl_q));

    p_ctrl_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_num == 5'd13) |=> (rd_data == $past(ctrl_q)));

    p_other_reg_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_num != 5'd13 && reg_num != 5'd14) |=> (rd_data == 16'h0000));

    p_adv_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && reg_num == 5'd14) |=> ($stable(eee_adv) && $stable(clk_stop_en)));

    p_adv_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eee_adv & 16'hFF81) == 16'h0000);

endmodule

bind mmd_indirect_bridge mmd_indirect_bridge_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_num     (reg_num),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .clk_stop_en (clk_stop_en),
    .eee_adv     (eee_adv),
    .ctrl_q      (ctrl_q)
);

// File: tb/mmd_indirect_bridge_tb_top.sv
module mmd_indirect_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  reg_num = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] lp_ability = 16'hFF0E;
    logic        wake_err = 1'b0;
    logic [15:0] rd_data;
    logic        rd_valid;
    logic        clk_stop_en;
    logic [15:0] eee_adv;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    mmd_indirect_bridge dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_num     (reg_num),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wr_data     (wr_data),
        .lp_ability  (lp_ability),
        .wake_err    (wake_err),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .clk_stop_en (clk_stop_en),
        .eee_adv     (eee_adv)
    );

    // {write, req number, register, data, expected}
    localparam int NVEC = 34;
    localparam logic [41:0] TBL [NVEC] = '{
        {1'b1, 4'd2,  5'd13, 16'h0003, 16'h0000}, // R2 dev 3, address function
        {1'b1, 4'd2,  5'd14, 16'h0014, 16'h0000}, // R2 latch index 20
        {1'b0, 4'd2,  5'd14, 16'h0000, 16'h0014}, // R2 read back index
        {1'b1, 4'd3,  5'd13, 16'h4003, 16'h0000}, // R3 data, no advance
        {1'b0, 4'd8,  5'd14, 16'h0000, 16'h0006}, // R8 capability word
        {1'b1, 4'd8,  5'd14, 16'hFFFF, 16'h0000}, // R8 write ignored
        {1'b0, 4'd3,  5'd14, 16'h0000, 16'h0006}, // R3 index unchanged
        {1'b0, 4'd1,  5'd13, 16'h0000, 16'h4003}, // R1 control readback
        {1'b1, 4'd6,  5'd13, 16'h0007, 16'h0000}, // R6 dev 7
        {1'b1, 4'd6,  5'd14, 16'h003C, 16'h0000}, // R6 index 60
        {1'b1, 4'd7,  5'd13, 16'h4007, 16'h0000}, // R7
        {1'b1, 4'd7,  5'd14, 16'hFFFF, 16'h0000}, // R7 write advert
        {1'b0, 4'd7,  5'd14, 16'h0000, 16'h007E}, // R7 masked to [6:1]
        {1'b1, 4'd6,  5'd13, 16'h0003, 16'h0000}, // R6 back to dev 3
        {1'b0, 4'd6,  5'd14, 16'h0000, 16'h0014}, // R6 dev 3 index kept
        {1'b1, 4'd7,  5'd14, 16'h0000, 16'h0000}, // R7 index 0
        {1'b1, 4'd7,  5'd13, 16'h4003, 16'h0000}, // R7
        {1'b1, 4'd7,  5'd14, 16'hFFFF, 16'h0000}, // R7 set clock stop
        {1'b0, 4'd7,  5'd14, 16'h0000, 16'h0400}, // R7 only bit 10
        {1'b1, 4'd4,  5'd13, 16'h0007, 16'h0000}, // R4
        {1'b1, 4'd4,  5'd13, 16'h8007, 16'h0000}, // R4 advance on rd and wr
        {1'b0, 4'd4,  5'd14, 16'h0000, 16'h007E}, // R4 index 60
        {1'b0, 4'd4,  5'd14, 16'h0000, 16'h000E}, // R4 index 61 partner
        {1'b0, 4'd4,  5'd14, 16'h0000, 16'h0000}, // R4 index 62
        {1'b1, 4'd4,  5'd14, 16'h0055, 16'h0000}, // R4 write index 63
        {1'b1, 4'd4,  5'd13, 16'h0007, 16'h0000}, // R4
        {1'b0, 4'd4,  5'd14, 16'h0000, 16'h0040}, // R4 index now 64
        {1'b1, 4'd5,  5'd14, 16'h003C, 16'h0000}, // R5 index 60
        {1'b1, 4'd5,  5'd13, 16'hC007, 16'h0000}, // R5 advance on wr only
        {1'b0, 4'd5,  5'd14, 16'h0000, 16'h007E}, // R5 read, no advance
        {1'b1, 4'd5,  5'd14, 16'h0002, 16'h0000}, // R5 write, advance
        {1'b0, 4'd5,  5'd14, 16'h0000, 16'h000E}, // R5 now at 61
        {1'b1, 4'd5,  5'd13, 16'h0007, 16'h0000}, // R5
        {1'b0, 4'd5,  5'd14, 16'h0000, 16'h003D}  // R5 index 61
    };

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_wr(input logic [4:0] r, input logic [15:0] d);
        reg_num = r; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_rd(input logic [4:0] r, input logic [15:0] exp, input string what);
        reg_num = r; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        check({what, " data"}, rd_data, exp);
        check({what, " valid"}, {15'd0, rd_valid}, 16'h0001);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 / R7 reset state at the ports
        check("R12 reset rd_valid", {15'd0, rd_valid}, 16'h0000);
        check("R7 reset clk_stop_en", {15'd0, clk_stop_en}, 16'h0000);
        check("R7 reset eee_adv", eee_adv, 16'h0000);
        do_rd(5'd13, 16'h0000, "R1 reset control");
        @(negedge clk);
        check("R12 valid drops", {15'd0, rd_valid}, 16'h0000);

        for (int i = 0; i < NVEC; i++) begin
            if (TBL[i][41]) begin
                do_wr(TBL[i][36:32], TBL[i][31:16]);
            end else begin
                do_rd(TBL[i][36:32], TBL[i][15:0],
                      $sformatf("R%0d table step %0d", TBL[i][40:37], i));
            end
        end
        check("R12 eee_adv port", eee_adv, 16'h0002);
        check("R12 clk_stop_en port", {15'd0, clk_stop_en}, 16'h0001);

        // R10 unimplemented device: read 0, write no effect
        do_wr(5'd13, 16'h0001);
        do_wr(5'd14, 16'h003C);
        do_wr(5'd13, 16'h4001);
        do_wr(5'd14, 16'hFFFF);
        do_rd(5'd14, 16'h0000, "R10 unimplemented dev read");
        check("R10 adv untouched", eee_adv, 16'h0002);
        // R10 other management registers
        do_wr(5'd5, 16'hBEEF);
        do_rd(5'd5, 16'h0000, "R10 other register read");
        do_rd(5'd13, 16'h4001, "R10 control untouched");

        // R11 wrap of the index
        do_wr(5'd13, 16'h0007);
        do_wr(5'd14, 16'hFFFF);
        do_wr(5'd13, 16'h8007);
        do_rd(5'd14, 16'h0000, "R10 unimplemented index read");
        do_wr(5'd13, 16'h0007);
        do_rd(5'd14, 16'h0000, "R11 index wrapped");

        // R9 wake-error counter
        wake_err = 1'b1;
        repeat (3) @(negedge clk);
        wake_err = 1'b0;
        do_wr(5'd13, 16'h0003);
        do_wr(5'd14, 16'h0016);
        do_wr(5'd13, 16'h4003);
        do_rd(5'd14, 16'h0003, "R9 counted pulses");
        do_rd(5'd14, 16'h0000, "R9 cleared on read");
        wake_err = 1'b1;
        do_rd(5'd14, 16'h0000, "R9 read with pulse");
        wake_err = 1'b0;
        do_rd(5'd14, 16'h0001, "R9 pulse kept over clear");

        // R1 / R6 mid-run reset
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset adv again", eee_adv, 16'h0000);
        do_rd(5'd13, 16'h0000, "R1 control after reset");
        do_rd(5'd14, 16'h0000, "R6 index after reset");

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule